// File: doc/BRIEF.md
# Memory Access Alignment Checker

This block sits beside the load/store issue logic of a processor core and decides, for each memory-access instruction, whether the access must trap to the alignment handler. It looks at more than address alignment. It takes a code for the instruction class, the low bits of the effective address and the operand size. It also takes page and segment attributes: a direct-store segment flag, a segment/protection-boundary-crossing flag, write-through and caching-inhibited. Finally it takes the current little-endian mode bit.

Every check runs in parallel. When more than one reason applies, a fixed priority picks one. The block registers the exception flag and a three-bit reason code on each cycle in which the valid strobe is high. Both outputs then hold until the next strobe, so the trap logic can sample them at its own pace. The block does not perform the access, split misaligned accesses or produce a vector address.

Top module: `mem_align_check`

## Requirements
- R1: While `rst` is high at a rising clock edge, `exc_o` becomes 0 and `reason_o` becomes 0 (no reason).
- R2: A floating-point load (class 2) or floating-point store (class 3) with `direct_store_i`=1 gives reason 1, whatever its alignment.
- R3: With `boundary_cross_i`=1, the following classes give reason 2: plain load (0), plain store (1), floating-point classes (2, 3), multiple-word (4 load, 5 store), reserve/conditional (6 load-reserve, 7 store-conditional) and string (8, 9 loads; 10, 11 stores). The external-control classes (12, 13), block zero (14) and class 15 (no memory access) ignore the crossing flag.
- R4: A floating-point load or store (classes 2, 3) whose `addr_lo_i[1:0]` is not 0 gives reason 3.
- R5: Classes 4, 5, 6 and 7 give reason 4 when `addr_lo_i[1:0]` is not 0.
- R6: An external-control read (12) or write (13) gives reason 5 when the address is not a multiple of the operand size. The operand size is `size_i`: 0 byte, 1 halfword, 2 word, 3 doubleword. The check uses the bits of `addr_lo_i` below 2^size_i.
- R7: The multiple-word classes (4, 5) and the string classes (8–11) give reason 6 when `little_endian_i`=1, whatever their alignment.
- R8: Block zero (class 14) gives reason 7 when `write_through_i` or `cache_inhibit_i` is 1.
- R9: When several reasons apply, the lowest-numbered one is reported. `exc_o` is 1 exactly when the reported reason is not 0.
- R10: The outputs change one clock edge after a cycle with `valid_i`=1. While `valid_i` is 0 they keep their values, whatever the other inputs do.
- R11: Plain loads and stores (0, 1) with `boundary_cross_i`=0 never raise the exception, whatever their alignment, size, endian mode or attributes. Class 15 never raises it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe: evaluate and register this access |
| class_i | input | 4 | Instruction class code |
| addr_lo_i | input | 3 | Low bits of the effective address |
| size_i | input | 2 | Operand size, log2 of bytes |
| direct_store_i | input | 1 | Target lies in a direct-store segment |
| boundary_cross_i | input | 1 | Access crosses into a direct-store segment or over a protection boundary |
| little_endian_i | input | 1 | Little-endian mode is active |
| write_through_i | input | 1 | Target page is write-through |
| cache_inhibit_i | input | 1 | Target page is caching-inhibited |
| exc_o | output | 1 | Alignment exception required |
| reason_o | output | 3 | Reported reason, 0 when none |

## Verification
The block has one register stage, so both `exc_o` and `reason_o` belong to the rising edge that follows the cycle in which a strobed access is driven. The bench drives each access on a falling edge. It compares both outputs on the next falling edge, which is half a period after the capturing edge and before any new stimulus. The hold checks use the same timing. They drive an access with the strobe low and changed inputs, then sample on each of the next two falling edges. A reset applied during a run is checked on the falling edge after the edge that sees it.

// File: rtl/mem_align_pkg.sv
package mem_align_pkg;

    localparam int CLASS_W  = 4;
    localparam int ADDR_W   = 3;
    localparam int SIZE_W   = 2;
    localparam int REASON_W = 3;
    localparam int N_REASON = 8;

    typedef enum logic [CLASS_W-1:0] {
        CL_LOAD      = 4'd0,
        CL_STORE     = 4'd1,
        CL_FP_LOAD   = 4'd2,
        CL_FP_STORE  = 4'd3,
        CL_LD_MULTI  = 4'd4,
        CL_ST_MULTI  = 4'd5,
        CL_LD_RSV    = 4'd6,
        CL_ST_COND   = 4'd7,
        CL_LD_STR_I  = 4'd8,
        CL_LD_STR_X  = 4'd9,
        CL_ST_STR_I  = 4'd10,
        CL_ST_STR_X  = 4'd11,
        CL_EXT_RD    = 4'd12,
        CL_EXT_WR    = 4'd13,
        CL_BLK_ZERO  = 4'd14,
        CL_OTHER     = 4'd15
    } acc_class_e;

    // Lower number wins when several apply.
    typedef enum logic [REASON_W-1:0] {
        RS_NONE        = 3'd0,
        RS_FP_DIRECT   = 3'd1,
        RS_CROSSING    = 3'd2,
        RS_FP_MISALIGN = 3'd3,
        RS_WORD_MISAL  = 3'd4,
        RS_EXT_MISAL   = 3'd5,
        RS_LE_MULTSTR  = 3'd6,
        RS_ZERO_ATTR   = 3'd7
    } reason_e;

    typedef struct packed {
        logic is_fp;
        logic is_multi;
        logic is_string;
        logic is_rsv;
        logic is_ext;
        logic is_zero;
        logic can_cross;
    } class_traits_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic              direct_store;
        logic              crossing;
        logic              little_endian;
        logic              write_through;
        logic              cache_inhibit;
    } access_attr_t;

    // True when any address bit below the operand size is set.
    function automatic logic size_misaligned(input logic [ADDR_W-1:0] a,
                                             input logic [SIZE_W-1:0] sz);
        logic [ADDR_W-1:0] mask;
        mask = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (b < int'(sz)) mask[b] = 1'b1;
        end
        return |(a & mask);
    endfunction

    function automatic logic word_misaligned(input logic [ADDR_W-1:0] a);
        return |a[1:0];
    endfunction

endpackage

// File: rtl/acc_class_decode.sv
module acc_class_decode
    import mem_align_pkg::*;
(
    input  logic [CLASS_W-1:0] class_i,
    output class_traits_t      traits_o
);
    acc_class_e cls;

    always_comb begin
        cls      = acc_class_e'(class_i);
        traits_o = '0;
        unique case (cls)
            CL_LOAD, CL_STORE: begin
                traits_o.can_cross = 1'b1;
            end
            CL_FP_LOAD, CL_FP_STORE: begin
                traits_o.is_fp     = 1'b1;
                traits_o.can_cross = 1'b1;
            end
            CL_LD_MULTI, CL_ST_MULTI: begin
                traits_o.is_multi  = 1'b1;
                traits_o.can_cross = 1'b1;
            end
            CL_LD_RSV, CL_ST_COND: begin
                traits_o.is_rsv    = 1'b1;
                traits_o.can_cross = 1'b1;
            end
            CL_LD_STR_I, CL_LD_STR_X, CL_ST_STR_I, CL_ST_STR_X: begin
                traits_o.is_string = 1'b1;
                traits_o.can_cross = 1'b1;
            end
            CL_EXT_RD, CL_EXT_WR: begin
                traits_o.is_ext    = 1'b1;
            end
            CL_BLK_ZERO: begin
                traits_o.is_zero   = 1'b1;
            end
            default: begin
                traits_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/align_rule_eval.sv
module align_rule_eval
    import mem_align_pkg::*;
(
    input  class_traits_t       traits_i,
    input  access_attr_t        attr_i,
    output logic [N_REASON-1:0] hits_o
);
    logic word_bad;
    logic size_bad;

    always_comb begin
        word_bad = word_misaligned(attr_i.addr);
        size_bad = size_misaligned(attr_i.addr, attr_i.size);

        hits_o = '0;
        hits_o[RS_FP_DIRECT]   = traits_i.is_fp & attr_i.direct_store;
        hits_o[RS_CROSSING]    = traits_i.can_cross & attr_i.crossing;
        hits_o[RS_FP_MISALIGN] = traits_i.is_fp & word_bad;
        hits_o[RS_WORD_MISAL]  = (traits_i.is_multi | traits_i.is_rsv) & word_bad;
        hits_o[RS_EXT_MISAL]   = traits_i.is_ext & size_bad;
        hits_o[RS_LE_MULTSTR]  = (traits_i.is_multi | traits_i.is_string)
                                 & attr_i.little_endian;
        hits_o[RS_ZERO_ATTR]   = traits_i.is_zero
                                 & (attr_i.write_through | attr_i.cache_inhibit);
    end
endmodule

// File: rtl/reason_prio_enc.sv
module reason_prio_enc #(
    parameter int N  = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] hits_i,
    output logic         any_o,
    output logic [W-1:0] code_o
);
    logic [N-1:0] lower_any;
    logic [N-1:0] grant;

    // Bit 0 means "no reason" and never takes part.
    assign lower_any[0] = 1'b0;
    assign grant[0]     = 1'b0;

    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            if (g == 1) begin : g_first
                assign lower_any[g] = 1'b0;
            end else begin : g_rest
                assign lower_any[g] = lower_any[g-1] | hits_i[g-1];
            end
            assign grant[g] = hits_i[g] & ~lower_any[g];
        end
    endgenerate

    always_comb begin
        code_o = '0;
        for (int i = 1; i < N; i++) begin
            if (grant[i]) code_o = code_o | W'(i);
        end
    end

    assign any_o = |hits_i[N-1:1];
endmodule

// File: rtl/mem_align_check.sv
module mem_align_check
    import mem_align_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid_i,
    input  logic [3:0] class_i,
    input  logic [2:0] addr_lo_i,
    input  logic [1:0] size_i,
    input  logic       direct_store_i,
    input  logic       boundary_cross_i,
    input  logic       little_endian_i,
    input  logic       write_through_i,
    input  logic       cache_inhibit_i,
    output logic       exc_o,
    output logic [2:0] reason_o
);
    class_traits_t         traits;
    access_attr_t          attr;
    logic [N_REASON-1:0]   hits;
    logic                  any_hit;
    logic [REASON_W-1:0]   code;
    logic                  exc_q;
    reason_e               reason_q;

    always_comb begin
        attr.addr          = addr_lo_i;
        attr.size          = size_i;
        attr.direct_store  = direct_store_i;
        attr.crossing      = boundary_cross_i;
        attr.little_endian = little_endian_i;
        attr.write_through = write_through_i;
        attr.cache_inhibit = cache_inhibit_i;
    end

    acc_class_decode u_decode (
        .class_i  (class_i),
        .traits_o (traits)
    );

    align_rule_eval u_rules (
        .traits_i (traits),
        .attr_i   (attr),
        .hits_o   (hits)
    );

    reason_prio_enc #(.N(N_REASON)) u_prio (
        .hits_i (hits),
        .any_o  (any_hit),
        .code_o (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_q    <= 1'b0;
            reason_q <= RS_NONE;
        end else if (valid_i) begin
            exc_q    <= any_hit;
            reason_q <= reason_e'(code);
        end
    end

    assign exc_o    = exc_q;
    assign reason_o = reason_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!exc_o && reason_o == RS_NONE));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(exc_o) && $stable(reason_o)));

    // R9
    flag_match_chk: assert property (@(posedge clk) disable iff (rst)
        exc_o == (reason_o != RS_NONE));

    // R2
    fp_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (class_i == CL_FP_LOAD || class_i == CL_FP_STORE) && direct_store_i)
        |=> (reason_o == RS_FP_DIRECT));

    // R8
    zero_attr_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && class_i == CL_BLK_ZERO && (write_through_i || cache_inhibit_i))
        |=> (exc_o && reason_o == RS_ZERO_ATTR));

    // R11
    plain_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (class_i == CL_LOAD || class_i == CL_STORE) && !boundary_cross_i)
        |=> !exc_o);
endmodule

// File: tb/mem_align_check_test.sv
module mem_align_check_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid_i = 1'b0;
    logic [3:0] class_i = '0;
    logic [2:0] addr_lo_i = '0;
    logic [1:0] size_i = '0;
    logic       direct_store_i = 1'b0;
    logic       boundary_cross_i = 1'b0;
    logic       little_endian_i = 1'b0;
    logic       write_through_i = 1'b0;
    logic       cache_inhibit_i = 1'b0;
    logic       exc_o;
    logic [2:0] reason_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mem_align_check uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .class_i(class_i),
        .addr_lo_i(addr_lo_i), .size_i(size_i), .direct_store_i(direct_store_i),
        .boundary_cross_i(boundary_cross_i), .little_endian_i(little_endian_i),
        .write_through_i(write_through_i), .cache_inhibit_i(cache_inhibit_i),
        .exc_o(exc_o), .reason_o(reason_o)
    );

    // Vector: class[16:13] addr[12:10] size[9:8] {ds,bx,le,wt,ci}[7:3] expected reason[2:0]
    localparam int NV = 28;
    localparam logic [16:0] VEC [NV] = '{
        {4'd0,  3'd1, 2'd0, 5'b00000, 3'd0},  // R11 plain load misaligned
        {4'd1,  3'd3, 2'd2, 5'b00111, 3'd0},  // R11 plain store, attrs set
        {4'd2,  3'd0, 2'd3, 5'b10000, 3'd1},  // R2
        {4'd3,  3'd4, 2'd2, 5'b00000, 3'd0},  // R4 aligned
        {4'd2,  3'd2, 2'd3, 5'b00000, 3'd3},  // R4
        {4'd3,  3'd1, 2'd2, 5'b10000, 3'd1},  // R9 1 over 3
        {4'd4,  3'd0, 2'd2, 5'b00000, 3'd0},  // R5 aligned
        {4'd4,  3'd2, 2'd2, 5'b00000, 3'd4},  // R5
        {4'd6,  3'd1, 2'd2, 5'b00000, 3'd4},  // R5
        {4'd7,  3'd4, 2'd2, 5'b00000, 3'd0},  // R5 aligned
        {4'd5,  3'd2, 2'd2, 5'b00100, 3'd4},  // R9 4 over 6
        {4'd8,  3'd1, 2'd0, 5'b00000, 3'd0},  // R7 big-endian string
        {4'd9,  3'd0, 2'd0, 5'b00100, 3'd6},  // R7
        {4'd11, 3'd3, 2'd0, 5'b01100, 3'd2},  // R3 / R9 2 over 6
        {4'd0,  3'd0, 2'd2, 5'b01000, 3'd2},  // R3 plain load
        {4'd12, 3'd2, 2'd2, 5'b00000, 3'd5},  // R6
        {4'd13, 3'd4, 2'd2, 5'b00000, 3'd0},  // R6 word ok
        {4'd13, 3'd4, 2'd3, 5'b00000, 3'd5},  // R6 dword misaligned
        {4'd12, 3'd0, 2'd2, 5'b01000, 3'd0},  // R3 ignored for ext
        {4'd14, 3'd0, 2'd0, 5'b00010, 3'd7},  // R8 write-through
        {4'd14, 3'd0, 2'd0, 5'b00001, 3'd7},  // R8 caching-inhibited
        {4'd14, 3'd3, 2'd0, 5'b01100, 3'd0},  // R8 no attrs, R3 ignored
        {4'd15, 3'd3, 2'd3, 5'b11111, 3'd0},  // R11 class 15
        {4'd5,  3'd0, 2'd2, 5'b00100, 3'd6},  // R7 multiple in LE
        {4'd3,  3'd0, 2'd3, 5'b01000, 3'd2},  // R3 fp crossing
        {4'd10, 3'd0, 2'd0, 5'b00100, 3'd6},  // R7
        {4'd6,  3'd0, 2'd2, 5'b00100, 3'd0},  // R7 reserve not affected
        {4'd0,  3'd0, 2'd0, 5'b10000, 3'd0}   // R11 direct-store plain
    };

    task automatic apply(input logic [16:0] v, input logic vld);
        @(negedge clk);
        valid_i          = vld;
        class_i          = v[16:13];
        addr_lo_i        = v[12:10];
        size_i           = v[9:8];
        direct_store_i   = v[7];
        boundary_cross_i = v[6];
        little_endian_i  = v[5];
        write_through_i  = v[4];
        cache_inhibit_i  = v[3];
    endtask

    task automatic check(input string req, input logic [2:0] exp_r);
        logic exp_e;
        exp_e = (exp_r != 3'd0);
        total++;
        if (exc_o !== exp_e || reason_o !== exp_r) begin
            bad++;
            $display("FAIL %s: exc=%0b reason=%0d expected exc=%0b reason=%0d",
                     req, exc_o, reason_o, exp_e, exp_r);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 3'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i], 1'b1);
            @(negedge clk);
            check($sformatf("vector %0d (R2-R9,R11)", i), VEC[i][2:0]);
        end

        // R10: set reason 7, then change inputs with strobe low
        apply({4'd14, 3'd0, 2'd0, 5'b00010, 3'd7}, 1'b1);
        @(negedge clk);
        check("R10 load", 3'd7);
        valid_i        = 1'b0;
        class_i        = 4'd2;
        direct_store_i = 1'b1;
        @(negedge clk);
        check("R10 hold 1", 3'd7);
        @(negedge clk);
        check("R10 hold 2", 3'd7);

        // R10: back-to-back strobes, each result one edge later
        apply({4'd2, 3'd0, 2'd3, 5'b10000, 3'd1}, 1'b1);
        apply({4'd12, 3'd1, 2'd1, 5'b00000, 3'd5}, 1'b1);
        check("R10 back-to-back first", 3'd1);
        apply({4'd1, 3'd0, 2'd0, 5'b00000, 3'd0}, 1'b0);
        check("R10 back-to-back second", 3'd5);

        // R1: reset during a run clears a held exception
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 3'd0);
        rst = 1'b0;

        // R6: halfword at even address is fine
        apply({4'd12, 3'd2, 2'd1, 5'b00000, 3'd0}, 1'b1);
        @(negedge clk);
        check("R6 halfword aligned", 3'd0);

        // R9: every rule on at once for a floating-point store
        apply({4'd3, 3'd3, 2'd3, 5'b11111, 3'd1}, 1'b1);
        @(negedge clk);
        check("R9 all rules fp", 3'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule